// File: doc/BRIEF.md
# Operand-Wait Issue Queue

This block holds decoded micro-operations for one execution slot until both of their source operands are known, then dispatches them one at a time to that slot's function unit. Each new micro-operation enters through a single fixed insertion slot (entry 0). Surviving entries are packed toward the older end of an eight-entry array every cycle, so the array index gives the relative age of the entries. Entries whose operands are still outstanding watch a result broadcast (valid, tag, value) and take the value when the tag matches.

In every cycle the queue dispatches the oldest entry whose two operands are both ready. Entries that are still waiting never block younger entries that are ready. If the insertion slot would still be occupied after this cycle's movement, the queue raises a combinational overflow, and the upstream stage must present the micro-operation again later. A repair command carries a checkpoint number. It discards every entry tagged with a younger checkpoint and keeps entries from the restored checkpoint and from older ones.

Top module: `opwait_issue_queue`

## Requirements
- R1: An accepted micro-operation is written into entry 0 at the clock edge. It can be dispatched no earlier than the cycle after that edge.
- R2: `overflow` is high in a cycle exactly when `ins_valid` is high, `repair` is low, and all DEPTH entries remain after this cycle's dispatch. The offered micro-operation is then discarded and never dispatched.
- R3: An operand that is not ready becomes ready when `res_valid` is high and `res_tag` equals its tag. It takes `res_val`, and that value is the one later presented on `iss_a`/`iss_b`.
- R4: An entry is eligible only when both operands were ready at the start of the cycle. A value captured in cycle t allows dispatch in cycle t+1 at the earliest.
- R5: At most one entry is dispatched per cycle, and it is the oldest eligible one. The other eligible entries are dispatched later, in age order.
- R6: Entries waiting on operands do not stop later micro-operations from being inserted, or from being dispatched ahead of them once those later ones are ready.
- R7: A result broadcast in the same cycle that a micro-operation is inserted is captured by the new entry.
- R8: On `repair`, each entry is discarded when d = (entry checkpoint − `repair_ckpt`) mod 2^CKPT_W lies in 1 .. 2^(CKPT_W−1)−1. Entries with d = 0 or with d ≥ 2^(CKPT_W−1) are kept.
- R9: In a repair cycle `iss_valid` and `overflow` are low, and the offered micro-operation is discarded.
- R10: Synchronous active-high `rst` empties the queue. `iss_valid` stays low until new micro-operations are inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | A micro-operation is offered for insertion |
| ins_op | input | OP_W | Operation code of the offered micro-operation |
| ins_dst | input | TAG_W | Destination tag of the offered micro-operation |
| ins_ckpt | input | CKPT_W | Checkpoint number of the offered micro-operation |
| ins_a_rdy | input | 1 | First operand already known |
| ins_a_tag | input | TAG_W | Producer tag of the first operand |
| ins_a_val | input | VAL_W | Value of the first operand when ready |
| ins_b_rdy | input | 1 | Second operand already known |
| ins_b_tag | input | TAG_W | Producer tag of the second operand |
| ins_b_val | input | VAL_W | Value of the second operand when ready |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_val | input | VAL_W | Value of the broadcast result |
| repair | input | 1 | Discard entries younger than `repair_ckpt` |
| repair_ckpt | input | CKPT_W | Checkpoint restored by the repair |
| overflow | output | 1 | Offered micro-operation cannot be accepted this cycle |
| iss_valid | output | 1 | A micro-operation is dispatched this cycle |
| iss_op | output | OP_W | Operation code of the dispatched entry |
| iss_dst | output | TAG_W | Destination tag of the dispatched entry |
| iss_a | output | VAL_W | First operand value of the dispatched entry |
| iss_b | output | VAL_W | Second operand value of the dispatched entry |

## Verification
A corrupted age order shows up at once as dispatches in the wrong order. The bench checks this with sets of entries that become ready together through one broadcast. A lost or misrouted capture shows up on `iss_a`/`iss_b` one cycle after the broadcast, or as an entry that never dispatches. An entry that leaks through an overflow or a repair shows up as an extra dispatch within a cycle or two of the event. The bench looks for it by keeping such rejected entries ready, or by waking them on purpose, and then expecting silence.

// File: rtl/oiq_pkg.sv
package oiq_pkg;

    parameter int OP_W   = 6;
    parameter int TAG_W  = 5;
    parameter int VAL_W  = 16;
    parameter int CKPT_W = 3;

    typedef struct packed {
        logic             rdy;
        logic [TAG_W-1:0] tag;
        logic [VAL_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic [CKPT_W-1:0] ckpt;
        opnd_t             src_a;
        opnd_t             src_b;
    } uop_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [VAL_W-1:0] val;
    } result_t;

    // Capture a broadcast value into a waiting operand.
    function automatic opnd_t snoop(opnd_t o, result_t r);
        opnd_t n;
        n = o;
        if (!o.rdy && r.valid && (r.tag == o.tag)) begin
            n.rdy = 1'b1;
            n.val = r.val;
        end
        return n;
    endfunction

    function automatic uop_t wake_uop(uop_t u, result_t r);
        uop_t n;
        n       = u;
        n.src_a = snoop(u.src_a, r);
        n.src_b = snoop(u.src_b, r);
        return n;
    endfunction

    function automatic logic is_ready(uop_t u);
        return u.valid && u.src_a.rdy && u.src_b.rdy;
    endfunction

    // Wrapped distance 1 .. half-range-1 means younger than the restored point.
    function automatic logic is_younger(logic [CKPT_W-1:0] c, logic [CKPT_W-1:0] r);
        logic [CKPT_W-1:0] d;
        d = c - r;
        return (d != '0) && !d[CKPT_W-1];
    endfunction

endpackage

// File: rtl/oiq_wakeup.sv
module oiq_wakeup
    import oiq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  uop_t [DEPTH-1:0] cur,
    input  result_t          res,
    output uop_t [DEPTH-1:0] woke
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign woke[g] = wake_uop(cur[g], res);
    end

endmodule

// File: rtl/oiq_select.sv
module oiq_select
    import oiq_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  uop_t [DEPTH-1:0] q,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Higher index is older: the last eligible index scanned wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (is_ready(q[i])) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/oiq_pack.sv
module oiq_pack
    import oiq_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  uop_t [DEPTH-1:0] src,
    input  logic [DEPTH-1:0] keep,
    output uop_t [DEPTH-1:0] dst,
    output logic             full
);

    // Survivors slide to the top of the array, keeping their order.
    always_comb begin
        logic [IDX_W-1:0] pos;
        dst  = '0;
        full = 1'b0;
        pos  = IDX_W'(DEPTH - 1);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (keep[i]) begin
                dst[pos] = src[i];
                if (pos == '0) full = 1'b1;
                pos = pos - 1'b1;
            end
        end
    end

endmodule

// File: rtl/opwait_issue_queue.sv
module opwait_issue_queue
    import oiq_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [OP_W-1:0]   ins_op,
    input  logic [TAG_W-1:0]  ins_dst,
    input  logic [CKPT_W-1:0] ins_ckpt,
    input  logic              ins_a_rdy,
    input  logic [TAG_W-1:0]  ins_a_tag,
    input  logic [VAL_W-1:0]  ins_a_val,
    input  logic              ins_b_rdy,
    input  logic [TAG_W-1:0]  ins_b_tag,
    input  logic [VAL_W-1:0]  ins_b_val,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [VAL_W-1:0]  res_val,
    input  logic              repair,
    input  logic [CKPT_W-1:0] repair_ckpt,
    output logic              overflow,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [VAL_W-1:0]  iss_a,
    output logic [VAL_W-1:0]  iss_b
);

    uop_t [DEPTH-1:0] q_r;
    uop_t [DEPTH-1:0] q_woke;
    uop_t [DEPTH-1:0] q_packed;
    uop_t [DEPTH-1:0] q_nxt;
    logic [DEPTH-1:0] keep;
    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] elig_vec;
    logic             sel_any;
    logic [IDX_W-1:0] sel_idx;
    logic             packed_full;
    logic             fire;
    logic             accept;
    result_t          res;
    uop_t             new_uop;
    uop_t             sel_uop;

    assign res = '{valid: res_valid, tag: res_tag, val: res_val};

    oiq_select #(.DEPTH(DEPTH)) u_select (
        .q   (q_r),
        .any (sel_any),
        .idx (sel_idx)
    );

    oiq_wakeup #(.DEPTH(DEPTH)) u_wakeup (
        .cur  (q_r),
        .res  (res),
        .woke (q_woke)
    );

    assign fire = sel_any && !repair;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid_vec[i] = q_r[i].valid;
            elig_vec[i]  = is_ready(q_r[i]);
            keep[i]      = q_r[i].valid
                         && !(repair && is_younger(q_r[i].ckpt, repair_ckpt))
                         && !(fire && (sel_idx == IDX_W'(i)));
        end
    end

    oiq_pack #(.DEPTH(DEPTH)) u_pack (
        .src  (q_woke),
        .keep (keep),
        .dst  (q_packed),
        .full (packed_full)
    );

    // Offered entry, with a same-cycle broadcast already applied.
    always_comb begin
        uop_t raw;
        raw.valid = 1'b1;
        raw.op    = ins_op;
        raw.dst   = ins_dst;
        raw.ckpt  = ins_ckpt;
        raw.src_a = '{rdy: ins_a_rdy, tag: ins_a_tag, val: ins_a_val};
        raw.src_b = '{rdy: ins_b_rdy, tag: ins_b_tag, val: ins_b_val};
        new_uop   = wake_uop(raw, res);
    end

    assign accept   = ins_valid && !repair && !packed_full;
    assign overflow = ins_valid && !repair && packed_full;

    always_comb begin
        q_nxt = q_packed;
        if (accept) q_nxt[0] = new_uop;
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nxt;
    end

    assign sel_uop   = q_r[sel_idx];
    assign iss_valid = fire;
    assign iss_op    = sel_uop.op;
    assign iss_dst   = sel_uop.dst;
    assign iss_a     = sel_uop.src_a.val;
    assign iss_b     = sel_uop.src_b.val;

    // R1: an accepted entry is present in the insertion slot next cycle
    a_r1_insert_slot: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !repair && !overflow) |=> q_r[0].valid);

    // R2: a rejected insertion never grows the occupancy
    a_r2_no_overflow_growth: assert property (@(posedge clk) disable iff (rst)
        overflow |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

    // R4: only entries with both operands ready are dispatched
    a_r4_issue_ready: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (sel_uop.valid && sel_uop.src_a.rdy && sel_uop.src_b.rdy));

    // R5: no eligible entry is older than the dispatched one
    a_r5_oldest_first: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (((elig_vec >> sel_idx) >> 1) == '0));

    // R9: a repair cycle never adds entries
    a_r9_repair_no_growth: assert property (@(posedge clk) disable iff (rst)
        repair |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

endmodule

// File: tb/tb_opwait_issue_queue.sv
module tb_opwait_issue_queue;
    import oiq_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              ins_valid;
    logic [OP_W-1:0]   ins_op;
    logic [TAG_W-1:0]  ins_dst;
    logic [CKPT_W-1:0] ins_ckpt;
    logic              ins_a_rdy;
    logic [TAG_W-1:0]  ins_a_tag;
    logic [VAL_W-1:0]  ins_a_val;
    logic              ins_b_rdy;
    logic [TAG_W-1:0]  ins_b_tag;
    logic [VAL_W-1:0]  ins_b_val;
    logic              res_valid;
    logic [TAG_W-1:0]  res_tag;
    logic [VAL_W-1:0]  res_val;
    logic              repair;
    logic [CKPT_W-1:0] repair_ckpt;
    logic              overflow;
    logic              iss_valid;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_dst;
    logic [VAL_W-1:0]  iss_a;
    logic [VAL_W-1:0]  iss_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    opwait_issue_queue dut (.*);

    typedef struct packed {
        logic        iv;
        logic [5:0]  op;
        logic        ar;
        logic [4:0]  at;
        logic [15:0] av;
        logic        br;
        logic [4:0]  bt;
        logic [15:0] bv;
        logic        bus;
        logic [4:0]  btag;
        logic [15:0] bval;
        logic        ev;
        logic [5:0]  eop;
        logic [15:0] ea;
        logic [15:0] eb;
    } vec_t;

    // Stimulus for one cycle and the dispatch expected in that same cycle.
    localparam vec_t VEC [15] = '{
        '{1, 1, 1, 0, 10, 1, 0, 11, 0, 0,  0, 0, 0,  0,  0},
        '{1, 2, 0, 5,  0, 1, 0, 21, 0, 0,  0, 1, 1, 10, 11},
        '{1, 3, 1, 0, 30, 1, 0, 31, 0, 0,  0, 0, 0,  0,  0},
        '{0, 0, 0, 0,  0, 0, 0,  0, 1, 5, 25, 1, 3, 30, 31},
        '{0, 0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 1, 2, 25, 21},
        '{1, 4, 1, 0, 40, 0, 6,  0, 1, 6, 46, 0, 0,  0,  0},
        '{1, 5, 1, 0, 50, 1, 0, 51, 0, 0,  0, 1, 4, 40, 46},
        '{1, 6, 1, 0, 60, 1, 0, 61, 0, 0,  0, 1, 5, 50, 51},
        '{0, 0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 1, 6, 60, 61},
        '{1, 7, 0, 7,  0, 1, 0, 71, 0, 0,  0, 0, 0,  0,  0},
        '{1, 8, 0, 7,  0, 1, 0, 81, 0, 0,  0, 0, 0,  0,  0},
        '{0, 0, 0, 0,  0, 0, 0,  0, 1, 7, 77, 0, 0,  0,  0},
        '{0, 0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 1, 7, 77, 71},
        '{0, 0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 1, 8, 77, 81},
        '{0, 0, 0, 0,  0, 0, 0,  0, 0, 0,  0, 0, 0,  0,  0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_iss(input string tag, input logic ev, input logic [5:0] eop,
                           input logic [15:0] ea, input logic [15:0] eb);
        chk({tag, " valid"}, 32'(iss_valid), 32'(ev));
        if (ev && iss_valid) begin
            chk({tag, " op"},  32'(iss_op),  32'(eop));
            chk({tag, " dst"}, 32'(iss_dst), 32'(eop[4:0]));
            chk({tag, " a"},   32'(iss_a),   32'(ea));
            chk({tag, " b"},   32'(iss_b),   32'(eb));
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_op = '0; ins_dst = '0; ins_ckpt = '0;
        ins_a_rdy = 0; ins_a_tag = '0; ins_a_val = '0;
        ins_b_rdy = 0; ins_b_tag = '0; ins_b_val = '0;
        res_valid = 0; res_tag = '0; res_val = '0;
        repair = 0; repair_ckpt = '0;
    endtask

    task automatic offer(input logic [5:0] op, input logic [2:0] ck,
                         input logic ar, input logic [4:0] at, input logic [15:0] av,
                         input logic br, input logic [4:0] bt, input logic [15:0] bv);
        ins_valid = 1; ins_op = op; ins_dst = op[4:0]; ins_ckpt = ck;
        ins_a_rdy = ar; ins_a_tag = at; ins_a_val = av;
        ins_b_rdy = br; ins_b_tag = bt; ins_b_val = bv;
    endtask

    task automatic bcast(input logic [4:0] t, input logic [15:0] v);
        res_valid = 1; res_tag = t; res_val = v;
    endtask

    // Inputs change at the falling edge; outputs are sampled 5 ns later.
    task automatic cyc_begin();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        do_reset();

        // R10: empty after reset
        #5;
        chk_iss("R10 reset idle", 0, 0, 0, 0);
        chk("R10 reset overflow", 32'(overflow), 0);

        // Table walk: R1 R3 R4 R5 R6 R7
        for (int k = 0; k < 15; k++) begin
            cyc_begin();
            if (VEC[k].iv)
                offer(VEC[k].op, 0, VEC[k].ar, VEC[k].at, VEC[k].av,
                      VEC[k].br, VEC[k].bt, VEC[k].bv);
            if (VEC[k].bus) bcast(VEC[k].btag, VEC[k].bval);
            #5;
            chk_iss($sformatf("R5 table step %0d", k), VEC[k].ev, VEC[k].eop, VEC[k].ea, VEC[k].eb);
            chk($sformatf("R2 table overflow step %0d", k), 32'(overflow), 0);
        end

        // R2: fill all entries with waiting work, then offer one more
        do_reset();
        for (int k = 0; k < 8; k++) begin
            cyc_begin();
            offer(6'(8'h10 + k), 0, 0, 9, 0, 1, 0, 16'(k));
            #5;
            chk($sformatf("R2 fill %0d overflow", k), 32'(overflow), 0);
            chk_iss("R6 fill idle", 0, 0, 0, 0);
        end
        cyc_begin();
        offer(6'h20, 0, 1, 0, 1, 1, 0, 2);
        #5;
        chk("R2 full overflow", 32'(overflow), 1);
        cyc_begin();
        bcast(9, 99);
        #5;
        chk_iss("R2 rejected entry absent", 0, 0, 0, 0);
        for (int k = 0; k < 8; k++) begin
            cyc_begin();
            #5;
            chk_iss($sformatf("R5 drain order %0d", k), 1, 6'(8'h10 + k), 99, 16'(k));
        end
        cyc_begin();
        #5;
        chk_iss("R2 drained", 0, 0, 0, 0);

        // R8 R9: repair back to checkpoint 1
        do_reset();
        cyc_begin(); offer(6'h30, 0, 0, 12, 0, 1, 0, 5); #5;
        cyc_begin(); offer(6'h31, 1, 0, 12, 0, 1, 0, 6); #5;
        cyc_begin(); offer(6'h32, 2, 0, 12, 0, 1, 0, 7); #5;
        cyc_begin(); offer(6'h35, 0, 1, 0, 1, 1, 0, 2); #5;
        cyc_begin();
        offer(6'h34, 1, 1, 0, 3, 1, 0, 4);
        repair = 1; repair_ckpt = 1;
        #5;
        chk_iss("R9 no dispatch during repair", 0, 0, 0, 0);
        chk("R9 overflow low during repair", 32'(overflow), 0);
        cyc_begin();
        bcast(12, 120);
        #5;
        chk_iss("R8 older checkpoint kept", 1, 6'h35, 1, 2);
        cyc_begin(); #5;
        chk_iss("R8 oldest survivor", 1, 6'h30, 120, 5);
        cyc_begin(); #5;
        chk_iss("R8 same checkpoint kept", 1, 6'h31, 120, 6);
        cyc_begin(); #5;
        chk_iss("R8 younger flushed R9 offer dropped", 0, 0, 0, 0);

        // R10: reset discards waiting entries
        cyc_begin(); offer(6'h3a, 0, 0, 14, 0, 1, 0, 1); #5;
        cyc_begin(); offer(6'h3b, 0, 0, 14, 0, 1, 0, 1); #5;
        do_reset();
        cyc_begin();
        bcast(14, 140);
        #5;
        chk_iss("R10 reset flush", 0, 0, 0, 0);
        cyc_begin(); #5;
        chk_iss("R10 reset flush later", 0, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule